// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Slice

This block is one slice of a small programmable logic array. A set of macrocells shares one AND plane. Each macrocell owns a fixed group of product terms and ORs them together. A per-macrocell polarity bit can invert the sum. The result either drives its pin directly or passes through a clocked flip-flop first. Each pin has an output-enable. When the enable is low, the pin becomes an extra input to the shared AND plane.

Every macrocell returns a feedback literal to the AND plane, so logic with more than two levels can be built inside the slice. A macrocell may use the feedback of any macrocell with a lower index. To keep the plane free of combinational loops, connections to its own feedback or to any higher-indexed feedback are ignored. The pad is split into a core-side triple of value, enable and sampled input. All ports are plain control and data, with no handshake.

Top module: `pal_macrocell_block`

## Requirements
- R1: Literal `i` of the plane is `in_i[i]` for `i < N_IN` and the feedback of macrocell `j` for `i = N_IN + j`. Product term `t` of macrocell `k` takes its mask from `cfg_and[((k*N_PT+t)*2*N_LIT) +: 2*N_LIT]`. In that mask, bit `2i` connects literal `i` true and bit `2i+1` connects it complemented. A term is the AND of its connected literals.
- R2: A product term with no connected literal contributes 0. A term that connects both polarities of one literal is 0.
- R3: The sum of macrocell `k` is the OR of its own N_PT terms, XORed with `cfg_inv[k]`.
- R4: With `cfg_oe[k]=1` and `cfg_reg[k]=0`, `pad_o[k]` shows the sum in the same cycle.
- R5: With `cfg_oe[k]=1` and `cfg_reg[k]=1`, `pad_o[k]` shows the sum captured at the previous rising clock edge. The flip-flop captures on every edge, whatever the mode.
- R6: `rst` is synchronous and active high. It clears every macrocell flip-flop at the next edge.
- R7: `pad_oe[k]` equals `cfg_oe[k]`. With `cfg_oe[k]=0`, `pad_o[k]` is 0.
- R8: With `cfg_oe[j]=0`, the feedback literal of macrocell `j` is `pad_i[j]`.
- R9: With `cfg_oe[j]=1`, the feedback literal of macrocell `j` is the flip-flop value when `cfg_reg[j]=1` and the sum otherwise. Macrocell `k>j` sees this literal in the same cycle.
- R10: Mask bits of macrocell `k` that point at the feedback of macrocell `j >= k` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| in_i | input | N_IN | Dedicated input literals |
| pad_i | input | N_MC | Sampled pin values |
| cfg_and | input | N_MC*N_PT*2*N_LIT | AND-plane connection mask |
| cfg_inv | input | N_MC | Per-macrocell polarity invert |
| cfg_reg | input | N_MC | Per-macrocell register select |
| cfg_oe | input | N_MC | Per-macrocell output enable |
| pad_o | output | N_MC | Pin output value |
| pad_oe | output | N_MC | Pin driver enable |

## Verification
Two paths can meet in one cycle. A later macrocell may read a feedback literal from an earlier one while that earlier macrocell's flip-flop is capturing a new sum. Whether the later macrocell sees the old or the new value then depends on the register select. The bench provokes this with directed chains, where a registered stage feeds a combinational one. It also uses random configurations in which registered, combinational and input-mode pins mix with feedback connections, and the inputs change every cycle. The expected output is judged against a bench model that evaluates the macrocells in index order. That model feeds back the flip-flop value held before the edge.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [1:0] {
    PIN_IN   = 2'd0,
    PIN_COMB = 2'd1,
    PIN_REG  = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e mode_of(input logic oe, input logic rsel);
    if (!oe)  return PIN_IN;
    if (rsel) return PIN_REG;
    return PIN_COMB;
  endfunction
endpackage

// File: rtl/pal_and_or_plane.sv
module pal_and_or_plane #(
  parameter int N_IN = 8,
  parameter int N_MC = 4,
  parameter int N_PT = 4,
  localparam int N_LIT = N_IN + N_MC,
  localparam int MASK_W = 2 * N_LIT,
  localparam int CFG_W = N_MC * N_PT * MASK_W
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_MC-1:0]  pin_in,
  input  logic [N_MC-1:0]  q_in,
  input  logic [CFG_W-1:0] cfg_and,
  input  logic [N_MC-1:0]  cfg_inv,
  input  logic [N_MC-1:0]  cfg_reg,
  input  logic [N_MC-1:0]  cfg_oe,
  output logic [N_MC-1:0]  sum_o
);
  always_comb begin
    logic [N_MC-1:0]   fbv;
    logic [N_MC-1:0]   res;
    logic [N_LIT-1:0]  lits;
    logic [MASK_W-1:0] m;
    logic acc, term, used, ok;
    fbv = '0;
    res = '0;
    for (int k = 0; k < N_MC; k++) begin
      lits = {fbv, in_i};
      acc = 1'b0;
      for (int t = 0; t < N_PT; t++) begin
        m = cfg_and[(k*N_PT + t)*MASK_W +: MASK_W];
        used = 1'b0;
        term = 1'b1;
        for (int i = 0; i < N_LIT; i++) begin
          ok = (i < N_IN + k);
          used = used | (ok & (m[2*i] | m[2*i+1]));
          if (ok & m[2*i]   & ~lits[i]) term = 1'b0;
          if (ok & m[2*i+1] &  lits[i]) term = 1'b0;
        end
        acc = acc | (used & term);
      end
      res[k] = acc ^ cfg_inv[k];
      fbv[k] = cfg_oe[k] ? (cfg_reg[k] ? q_in[k] : res[k]) : pin_in[k];
    end
    sum_o = res;
  end
endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_mc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sum_i,
  input  logic oe_i,
  input  logic rsel_i,
  output logic q_o,
  output logic pad_o,
  output logic pad_oe
);
  pin_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= sum_i;
  end

  always_comb begin
    mode = mode_of(oe_i, rsel_i);
    unique case (mode)
      PIN_REG:  pad_o = q_o;
      PIN_COMB: pad_o = sum_i;
      default:  pad_o = 1'b0;
    endcase
    pad_oe = (mode != PIN_IN);
  end
endmodule

// File: rtl/pal_macrocell_block.sv
module pal_macrocell_block #(
  parameter int N_IN = 8,
  parameter int N_MC = 4,
  parameter int N_PT = 4,
  localparam int N_LIT = N_IN + N_MC,
  localparam int CFG_W = N_MC * N_PT * 2 * N_LIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  in_i,
  input  logic [N_MC-1:0]  pad_i,
  input  logic [CFG_W-1:0] cfg_and,
  input  logic [N_MC-1:0]  cfg_inv,
  input  logic [N_MC-1:0]  cfg_reg,
  input  logic [N_MC-1:0]  cfg_oe,
  output logic [N_MC-1:0]  pad_o,
  output logic [N_MC-1:0]  pad_oe
);
  logic [N_MC-1:0] sum_w;
  logic [N_MC-1:0] q_w;

  pal_and_or_plane #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u_plane (
    .in_i    (in_i),
    .pin_in  (pad_i),
    .q_in    (q_w),
    .cfg_and (cfg_and),
    .cfg_inv (cfg_inv),
    .cfg_reg (cfg_reg),
    .cfg_oe  (cfg_oe),
    .sum_o   (sum_w)
  );

  for (genvar k = 0; k < N_MC; k++) begin : g_cell
    pal_out_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .sum_i  (sum_w[k]),
      .oe_i   (cfg_oe[k]),
      .rsel_i (cfg_reg[k]),
      .q_o    (q_w[k]),
      .pad_o  (pad_o[k]),
      .pad_oe (pad_oe[k])
    );
  end
endmodule

// File: rtl/pal_macrocell_block_chk.sv
module pal_macrocell_block_chk #(
  parameter int N_IN = 8,
  parameter int N_MC = 4,
  parameter int N_PT = 4,
  localparam int N_LIT = N_IN + N_MC,
  localparam int MASK_W = 2 * N_LIT,
  localparam int CFG_W = N_MC * N_PT * MASK_W
) (
  input logic             clk,
  input logic             rst,
  input logic [N_IN-1:0]  in_i,
  input logic [N_MC-1:0]  pad_i,
  input logic [CFG_W-1:0] cfg_and,
  input logic [N_MC-1:0]  cfg_inv,
  input logic [N_MC-1:0]  cfg_reg,
  input logic [N_MC-1:0]  cfg_oe,
  input logic [N_MC-1:0]  pad_o,
  input logic [N_MC-1:0]  sum_w
);
  for (genvar k = 0; k < N_MC; k++) begin : g_k
    a_r5_reg_capture: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((cfg_oe[k] && cfg_reg[k]) -> (pad_o[k] == $past(sum_w[k]))));

    a_r2_blank_plane: assert property (@(posedge clk) disable iff (rst)
      (cfg_and[k*N_PT*MASK_W +: N_PT*MASK_W] == '0) |-> (sum_w[k] == cfg_inv[k]));
  end

  a_r3_polarity_mc0: assert property (@(posedge clk) disable iff (rst)
    ($stable(in_i) && $stable(cfg_and) && (cfg_inv[0] != $past(cfg_inv[0])))
      |-> (sum_w[0] != $past(sum_w[0])));

  a_r4_comb_settle: assert property (@(posedge clk) disable iff (rst)
    ($stable(in_i) && $stable(pad_i) && $stable(cfg_and) && $stable(cfg_inv) &&
     $stable(cfg_oe) && (cfg_reg == '0) && ($past(cfg_reg) == '0))
      |-> $stable(pad_o));
endmodule

bind pal_macrocell_block pal_macrocell_block_chk #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_i    (in_i),
  .pad_i   (pad_i),
  .cfg_and (cfg_and),
  .cfg_inv (cfg_inv),
  .cfg_reg (cfg_reg),
  .cfg_oe  (cfg_oe),
  .pad_o   (pad_o),
  .sum_w   (sum_w)
);

// File: tb/test_pal_macrocell_block.sv
`timescale 1ns/1ps
module test_pal_macrocell_block;
  localparam int N_IN = 8;
  localparam int N_MC = 4;
  localparam int N_PT = 4;
  localparam int N_LIT = N_IN + N_MC;
  localparam int MW = 2 * N_LIT;
  localparam int CFG_W = N_MC * N_PT * MW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0]  in_i = '0;
  logic [N_MC-1:0]  pad_i = '0;
  logic [CFG_W-1:0] cfg_and = '0;
  logic [N_MC-1:0]  cfg_inv = '0;
  logic [N_MC-1:0]  cfg_reg = '0;
  logic [N_MC-1:0]  cfg_oe = '0;
  logic [N_MC-1:0]  pad_o;
  logic [N_MC-1:0]  pad_oe;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [N_MC-1:0] mq = '0;
  logic [N_MC-1:0] esum;
  logic [N_MC-1:0] epo;

  always #5 clk = ~clk;

  pal_macrocell_block #(.N_IN(N_IN), .N_MC(N_MC), .N_PT(N_PT)) i_pal_macrocell_block (
    .clk(clk), .rst(rst), .in_i(in_i), .pad_i(pad_i), .cfg_and(cfg_and),
    .cfg_inv(cfg_inv), .cfg_reg(cfg_reg), .cfg_oe(cfg_oe),
    .pad_o(pad_o), .pad_oe(pad_oe)
  );

  task automatic model();
    logic [N_MC-1:0] fb;
    logic [N_LIT-1:0] lits;
    fb = '0;
    for (int k = 0; k < N_MC; k++) begin
      logic s;
      lits = {fb, in_i};
      s = 1'b0;
      for (int t = 0; t < N_PT; t++) begin
        bit any;
        bit val;
        any = 0;
        val = 1;
        for (int i = 0; i < N_IN + k; i++) begin
          bit ct;
          bit cc;
          ct = cfg_and[(k*N_PT+t)*MW + 2*i];
          cc = cfg_and[(k*N_PT+t)*MW + 2*i + 1];
          if (ct || cc) any = 1;
          if (ct && !lits[i]) val = 0;
          if (cc && lits[i])  val = 0;
        end
        if (any && val) s = 1'b1;
      end
      esum[k] = s ^ cfg_inv[k];
      epo[k]  = !cfg_oe[k] ? 1'b0 : (cfg_reg[k] ? mq[k] : esum[k]);
      fb[k]   = cfg_oe[k] ? (cfg_reg[k] ? mq[k] : esum[k]) : pad_i[k];
    end
  endtask

  task automatic connect(input int k, input int t, input int lit, input bit neg);
    cfg_and[(k*N_PT+t)*MW + 2*lit + (neg ? 1 : 0)] = 1'b1;
  endtask

  // caller sets inputs after a falling edge; this checks, then advances one cycle
  task automatic cyc(input string tag);
    #1;
    model();
    for (int k = 0; k < N_MC; k++) begin
      string rq;
      rq = (tag != "") ? tag : (!cfg_oe[k] ? "R7" : (cfg_reg[k] ? "R5" : "R4"));
      n_tests++;
      if (pad_o[k] !== epo[k]) begin
        n_fail++;
        $display("FAIL %s pad_o[%0d] actual=%b expected=%b", rq, k, pad_o[k], epo[k]);
      end
    end
    n_tests++;
    if (pad_oe !== cfg_oe) begin
      n_fail++;
      $display("FAIL R7 pad_oe actual=%b expected=%b", pad_oe, cfg_oe);
    end
    @(posedge clk);
    mq = rst ? '0 : esum;
    @(negedge clk);
  endtask

  task automatic rand_cfg();
    for (int b = 0; b < CFG_W; b++) cfg_and[b] = (($urandom % 10) == 0);
    cfg_inv = N_MC'($urandom);
    cfg_reg = N_MC'($urandom);
    cfg_oe  = N_MC'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    rand_cfg();
    cfg_reg = '1;
    cfg_oe  = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R6: registered outputs read 0 while reset holds
    in_i = 8'hA5;
    cyc("R6");
    cyc("R6");
    rst = 1'b0;

    // R2: empty plane gives the polarity bit; double-polarity term gives 0
    cfg_and = '0; cfg_reg = '0; cfg_oe = '1; cfg_inv = 4'b0101;
    cyc("R2");
    cfg_inv = '0;
    connect(0, 1, 0, 0); connect(0, 1, 0, 1);
    in_i = 8'h01; cyc("R2");
    in_i = 8'h00; cyc("R2");

    // R1: mc0 term0 = in0 & ~in1 ; R3 polarity
    cfg_and = '0;
    connect(0, 0, 0, 0); connect(0, 0, 1, 1);
    in_i = 8'h01; cyc("R1");
    in_i = 8'h03; cyc("R1");
    in_i = 8'h01; cfg_inv[0] = 1'b1; cyc("R3");
    cfg_inv[0] = 1'b0;
    // R3: OR across two terms of mc0 (term2 = in7)
    connect(0, 2, 7, 0);
    in_i = 8'h80; cyc("R3");

    // R10: own and higher feedback ignored
    cfg_and = '0;
    connect(0, 0, N_IN + 0, 0);
    connect(1, 0, N_IN + 2, 1); connect(1, 0, 3, 0);
    connect(1, 1, N_IN + 1, 0);
    in_i = 8'h08; cyc("R10");
    in_i = 8'h00; cyc("R10");

    // R8: pin 0 as input feeding mc1
    cfg_and = '0; cfg_oe = 4'b1110;
    connect(1, 0, N_IN + 0, 0);
    pad_i = 4'b0001; cyc("R8");
    pad_i = 4'b0000; cyc("R8");
    pad_i = 4'b0001; cyc("R8");

    // R9: chain mc0=in0, mc1=fb0&in1, mc2=~fb1; mc0 registered then combinational
    cfg_and = '0; cfg_oe = '1; cfg_reg = 4'b0001; pad_i = '0;
    connect(0, 0, 0, 0);
    connect(1, 0, N_IN + 0, 0); connect(1, 0, 1, 0);
    connect(2, 0, N_IN + 1, 1);
    in_i = 8'h03; cyc("R9");
    in_i = 8'h02; cyc("R9");
    cyc("R9");
    cfg_reg = '0;
    in_i = 8'h03; cyc("R9");

    // R6: reset mid-run clears registered state
    cfg_reg = '1; in_i = 8'h01; cyc("R5");
    rst = 1'b1; cyc("R6");
    cyc("R6");
    rst = 1'b0;

    // random mix
    for (int n = 0; n < 600; n++) begin
      if (n % 20 == 0) rand_cfg();
      in_i  = N_IN'($urandom);
      pad_i = N_MC'($urandom);
      cyc("");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule